// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Manager

This block takes a wide bank of interrupt request lines and routes each one onto a priority channel through a programmable source selector. Channel numbers double as priorities: the lowest-numbered channel that is both pending and enabled wins. Each cycle the block registers the winning channel, a valid flag and a request output. It also reads a vector word out of a small internal table so that the vector appears on the same edge as the channel.

Software programs the block through a single write port. The port carries three kinds of write: the source chosen for a channel, the channel's enable bit, and a word of the vector table. Slot 0 of the table is kept for a phantom handler. It is returned whenever nothing is pending, and for the last channel, which has no slot of its own. Every other channel n finds its handler in slot n+1. Channel 0 carries the non-maskable error source, so its enable bit cannot be cleared.

Top module: `intr_vec_mgr`

## Requirements
- R1: After a synchronous reset, `act_valid`, `irq_req` and `act_chan` are all 0. Every channel c selects source c. Only channel 0 is enabled.
- R2: When several enabled channels are pending, `act_chan` is the lowest-numbered one. `act_valid` and `irq_req` are 1 exactly when at least one enabled channel was pending in the previous cycle.
- R3: A channel whose enable bit is 0 never asserts `irq_req` or appears on `act_chan`, whatever its source does.
- R4: A write that clears channel 0's enable bit has no effect: channel 0 still requests when its source is high.
- R5: Channel c is pending when the source named by its selector is high. A selector write with `wr_sel`=0 stores `wr_data[6:0]` as the source index for channel `wr_addr`.
- R6: An enable write with `wr_sel`=1 stores `wr_data[0]` as the enable of channel `wr_addr`. Requests seen at one clock edge appear on `act_chan`/`act_valid` at that edge, with no extra cycle of latency.
- R7: `act_vec` shows table slot `act_chan`+1 on the same edge that `act_chan` updates. When no enabled channel is pending, it shows slot 0 (the phantom entry).
- R8: Channel 127 can be mapped and enabled, and it then wins with `act_chan`=127 and `irq_req`=1. Its vector is slot 0.
- R9: A vector write with `wr_sel`=2 stores `wr_data` into table slot `wr_addr`. Writes with `wr_sel`=3, or with `wr_en` low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 128 | Interrupt request sources, level sensitive |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 selector, 1 enable, 2 vector slot, 3 none |
| wr_addr | input | 7 | Channel number or vector slot |
| wr_data | input | 32 | Write data |
| irq_req | output | 1 | Registered interrupt request |
| act_valid | output | 1 | Active channel is valid |
| act_chan | output | 7 | Highest-priority pending enabled channel |
| act_vec | output | 32 | Vector word for the active channel, or the phantom entry |

## Verification
The directed cases each isolate one rule. A single pending channel shows the n+1 vector offset. Two pending channels show the lowest-index ordering. A disabled pending channel shows masking apart from an idle source. A remapped channel driven by a foreign source shows that routing happens before enable. Channel 127 shows its phantom vector apart from the normal slot lookup. The random phase mixes sparse request patterns with random selector, enable and vector writes, so ordering, masking and remapping all interact. A bench model then predicts the channel and the vector.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;
  typedef enum logic [1:0] {
    WSEL_MAP  = 2'd0,
    WSEL_EN   = 2'd1,
    WSEL_VEC  = 2'd2,
    WSEL_NONE = 2'd3
  } wsel_e;
endpackage

// File: rtl/intr_route.sv
module intr_route #(
  parameter int NUM_CH  = 128,
  parameter int NUM_SRC = 128,
  parameter int CH_W    = $clog2(NUM_CH),
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic               map_we,
  input  logic               en_we,
  input  logic [CH_W-1:0]    addr,
  input  logic [SRC_W-1:0]   map_data,
  input  logic               en_data,
  output logic [NUM_CH-1:0]  en_q,
  output logic [NUM_CH-1:0]  masked
);
  logic [SRC_W-1:0] sel_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam bit IS_NMI = (c == 0);
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[c] <= SRC_W'(c);
        en_q[c]  <= IS_NMI;
      end else begin
        if (map_we && addr == CH_W'(c)) sel_q[c] <= map_data;
        if (en_we && addr == CH_W'(c))  en_q[c]  <= IS_NMI ? 1'b1 : en_data;
      end
    end
    assign masked[c] = src[sel_q[c]] & en_q[c];
  end
endmodule

// File: rtl/intr_prio.sv
module intr_prio #(
  parameter int NUM_CH = 128,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend,
  output logic              found,
  output logic [CH_W-1:0]   win
);
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        win   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/intr_vec_ram.sv
module intr_vec_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/intr_vec_mgr.sv
module intr_vec_mgr
  import intr_vec_pkg::*;
#(
  parameter int NUM_CH  = 128,
  parameter int NUM_SRC = 128,
  parameter int VEC_W   = 32,
  parameter int CH_W    = $clog2(NUM_CH),
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CH_W-1:0]    wr_addr,
  input  logic [VEC_W-1:0]   wr_data,
  output logic               irq_req,
  output logic               act_valid,
  output logic [CH_W-1:0]    act_chan,
  output logic [VEC_W-1:0]   act_vec
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] masked;
  logic              nxt_found;
  logic [CH_W-1:0]   nxt_win;
  logic [CH_W-1:0]   rd_slot;
  wsel_e             sel;

  assign sel = wsel_e'(wr_sel);

  intr_route #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) u_route (
    .clk      (clk),
    .rst      (rst),
    .src      (irq_src),
    .map_we   (wr_en && sel == WSEL_MAP),
    .en_we    (wr_en && sel == WSEL_EN),
    .addr     (wr_addr),
    .map_data (wr_data[SRC_W-1:0]),
    .en_data  (wr_data[0]),
    .en_q     (en_q),
    .masked   (masked)
  );

  intr_prio #(.NUM_CH(NUM_CH)) u_prio (
    .pend  (masked),
    .found (nxt_found),
    .win   (nxt_win)
  );

  // slot 0 is the phantom entry; the last channel has no slot of its own
  assign rd_slot = (nxt_found && nxt_win != LAST_CH) ? nxt_win + 1'b1 : '0;

  intr_vec_ram #(.DEPTH(NUM_CH), .W(VEC_W)) u_ram (
    .clk   (clk),
    .we    (wr_en && sel == WSEL_VEC),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_slot),
    .rdata (act_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      act_chan  <= '0;
      irq_req   <= 1'b0;
    end else begin
      act_valid <= nxt_found;
      act_chan  <= nxt_win;
      irq_req   <= nxt_found;
    end
  end
endmodule

// File: rtl/intr_vec_mgr_chk.sv
module intr_vec_mgr_chk #(
  parameter int NUM_CH = 128,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              act_valid,
  input logic              irq_req,
  input logic [CH_W-1:0]   act_chan,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] masked
);
  logic [NUM_CH-1:0] lower_mask;
  always_comb begin
    lower_mask = '0;
    for (int i = 0; i < NUM_CH; i++) lower_mask[i] = (i < int'(act_chan));
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!act_valid && !irq_req && act_chan == '0));

  // R2
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && act_valid) |-> (($past(masked) & lower_mask) == '0));

  // R2
  valid_tracks_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (act_valid == (|$past(masked))));

  // R3
  active_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && act_valid) |-> $past(en_q[act_chan]));

  // R4
  nmi_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> en_q[0]);
endmodule

bind intr_vec_mgr intr_vec_mgr_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .act_valid (act_valid),
  .irq_req   (irq_req),
  .act_chan  (act_chan),
  .en_q      (en_q),
  .masked    (masked)
);

// File: tb/intr_vec_mgr_tb.sv
module intr_vec_mgr_tb;
  localparam int N = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_src = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [6:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          irq_req, act_valid;
  logic [6:0]    act_chan;
  logic [31:0]   act_vec;

  int checks = 0;
  int errors = 0;

  logic [6:0]  m_map [N];
  logic        m_en  [N];
  logic [31:0] m_vec [N];

  always #2.5 clk = ~clk;

  intr_vec_mgr u_dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_req(irq_req),
    .act_valid(act_valid), .act_chan(act_chan), .act_vec(act_vec)
  );

  function automatic logic [39:0] expect_out(input logic [N-1:0] s);
    logic v; logic [6:0] c; logic [31:0] vec;
    v = 1'b0; c = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m_en[i] && s[m_map[i]]) begin v = 1'b1; c = 7'(i); end
    vec = (v && c != 7'd127) ? m_vec[c + 7'd1] : m_vec[0];
    return {v, c, vec};
  endfunction

  task automatic do_write(input logic [1:0] s, input logic [6:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (s == 2'd0) m_map[a] = d[6:0];
    else if (s == 2'd1) m_en[a] = (a == 7'd0) ? 1'b1 : d[0];
    else if (s == 2'd2) m_vec[a] = d;
  endtask

  task automatic check_src(input logic [N-1:0] s, input string req);
    logic [39:0] e;
    irq_src = s;
    e = expect_out(s);
    @(posedge clk); @(negedge clk);
    checks++;
    if (act_valid !== e[39] || irq_req !== e[39] || act_chan !== e[38:32] || act_vec !== e[31:0]) begin
      errors++;
      $display("FAIL %s: got v=%0b irq=%0b ch=%0d vec=%h, exp v=%0b ch=%0d vec=%h",
               req, act_valid, irq_req, act_chan, act_vec, e[39], e[38:32], e[31:0]);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] s;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin m_map[i] = 7'(i); m_en[i] = (i == 0); m_vec[i] = 'x; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (act_valid !== 1'b0 || irq_req !== 1'b0 || act_chan !== 7'd0) begin
      errors++;
      $display("FAIL R1: got v=%0b irq=%0b ch=%0d, exp 0 0 0", act_valid, irq_req, act_chan);
    end
    // R9 fill table
    for (int i = 0; i < N; i++) do_write(2'd2, 7'(i), 32'hA000_0000 + 32'(i) * 32'h11);
    // R1/R7: only channel 0 enabled; idle source gives phantom
    check_src('0, "R7 idle phantom");
    // R3: enabled by default only ch0, so ch5 pending is masked
    s = '0; s[5] = 1'b1;
    check_src(s, "R3 disabled ignored");
    // R1/R7: channel 0 requests with slot 1
    s = '0; s[0] = 1'b1;
    check_src(s, "R7 ch0 slot1");
    // R4: clearing ch0 enable has no effect
    do_write(2'd1, 7'd0, 32'd0);
    check_src(s, "R4 nmi unmaskable");
    // R6: enable ch5 and ch9
    do_write(2'd1, 7'd5, 32'd1);
    do_write(2'd1, 7'd9, 32'd1);
    s = '0; s[9] = 1'b1;
    check_src(s, "R6 single ch9");
    // R2: two pending
    s[5] = 1'b1;
    check_src(s, "R2 lower wins");
    s[0] = 1'b1;
    check_src(s, "R2 ch0 wins");
    // R5: remap ch3 to source 100
    do_write(2'd0, 7'd3, 32'd100);
    do_write(2'd1, 7'd3, 32'd1);
    s = '0; s[100] = 1'b1;
    check_src(s, "R5 remap routes");
    s = '0; s[3] = 1'b1;
    check_src(s, "R5 old source ignored");
    // R8: channel 127
    do_write(2'd1, 7'd127, 32'd1);
    s = '0; s[127] = 1'b1;
    check_src(s, "R8 ch127 phantom");
    // R9: wr_sel 3 changes nothing (phantom slot seen when idle)
    do_write(2'd3, 7'd0, 32'hDEAD_BEEF);
    check_src('0, "R9 sel3 ignored");
    // R9: vector rewrite visible
    do_write(2'd2, 7'd10, 32'h1234_5678);
    s = '0; s[9] = 1'b1;
    check_src(s, "R9 vector rewrite");
    // R3: disable ch9 again
    do_write(2'd1, 7'd9, 32'd0);
    check_src(s, "R3 disable drops");
    // random phase
    for (int it = 0; it < 400; it++) begin
      int nw;
      nw = $urandom_range(0, 3);
      for (int k = 0; k < nw; k++)
        do_write(2'($urandom_range(0, 3)), 7'($urandom_range(0, 127)), $urandom());
      s = '0;
      for (int b = 0; b < N; b++) s[b] = ($urandom_range(0, 31) == 0);
      check_src(s, "R2 R5 R6 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule